// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master and the two strobes that pace its data line. A strobe marks the cycle in which new transmit data is placed on SDA, and the other marks the cycle in which SDA is sampled. All timing comes from programmable counts in reference-clock cycles. The counts are the high period, the low period, a sample point inside the high phase, a drive point inside the low phase, a lead-in after START and a bus-free gap after STOP. The hardware adds a fixed overhead to each phase: 2 cycles to the low count and 7 cycles to the high count.

A byte engine above this block issues operations on a small command port. START is taken only while the bus is idle. BIT and STOP are taken only when the generator reports that it can take the next bit. If the next operation is already waiting when a high phase or the START lead-in ends, it is taken in that same cycle, so bits follow each other without gaps. If no operation is waiting, SCL parks low. A hold input can stretch any low phase at its end. During a hold SCL stays low and all counting stops.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, scl_o is 1, bus_idle_o is 1, and start_phase_o, stop_phase_o, bit_ready_o, tx_stb_o and rx_stb_o are all 0.
- R2: Op code 1 (START) is taken while the bus is idle. It drives start_phase_o high with scl_o high for lead_eff cycles, and then scl_o falls.
- R3: Each low phase of a bit lasts low_eff + 2 cycles when the next operation is already waiting.
- R4: Each high phase of a bit lasts high_eff + 7 cycles.
- R5: tx_stb_o pulses once in each low phase. The pulse comes min(tx_eff, L - 2) cycles after the fall of SCL, where L is the low-phase length.
- R6: rx_stb_o pulses once in the high phase of each bit. The pulse comes min(rx_eff, H - 1) cycles after the rise of SCL, where H is the high-phase length.
- R7: Op code 2 (STOP) holds stop_phase_o high for one low phase of length L and then one high phase of length H. After that stop_phase_o drops, and SCL stays high for bf_eff cycles before bus_idle_o rises.
- R8: While hold_i is 1, a low phase that has reached its last cycle stays low and does not advance. tx_stb_o does not pulse again. The high phase starts in the cycle after hold_i drops.
- R9: Every count field of value 0 acts as 1. Here x_eff means x when x is nonzero and 1 otherwise.
- R10: An operation outside its window has no effect. START is ignored unless bus_idle_o is 1. BIT (op code 0) and STOP are ignored unless bit_ready_o is 1. Op code 3 does nothing.
- R11: The three timing words are split into fields as follows:
  - tim_high_i holds the high count in [31:16] and the receive-sample offset in [15:0].
  - tim_low_i holds the low count in [31:16] and the transmit-change offset in [15:0].
  - tim_edge_i holds the bus-free count in [31:16] and the lead-in count in [15:0].
- R12: bit_ready_o is 1 in the last cycle of the lead-in, in the last cycle of a bit's high phase, and while SCL is parked low. If no operation is taken in such a cycle, SCL parks low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_go_i | input | 1 | Operation request valid |
| op_i | input | 2 | Operation code: 0 BIT, 1 START, 2 STOP, 3 none |
| hold_i | input | 1 | Hold SCL low at the end of a low phase |
| tim_high_i | input | 32 | High count and receive-sample offset |
| tim_low_i | input | 32 | Low count and transmit-change offset |
| tim_edge_i | input | 32 | Bus-free count and lead-in count |
| scl_o | output | 1 | SCL level (1 = released high) |
| tx_stb_o | output | 1 | Change-SDA strobe |
| rx_stb_o | output | 1 | Sample-SDA strobe |
| start_phase_o | output | 1 | START held: SDA low while SCL high |
| stop_phase_o | output | 1 | STOP set-up: SDA held low |
| bus_idle_o | output | 1 | Bus free, START may be issued |
| bit_ready_o | output | 1 | Next BIT or STOP is taken this cycle |

## Verification
The bench builds the block with its default parameters: 16-bit count fields and overheads of 2 and 7. These defaults make the fixed overhead directly visible in every measured width. The stimulus table covers four timing sets: typical counts, all-zero counts, offsets larger than their phase so that they must be clipped, and long counts. Directed runs cover a held low phase, a parked clock, and operations that arrive outside their window. A final run uses a high count near the top of the 16-bit field, so the phase length needs the extra counter bit.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BFREE = 3'd1,
        PH_LEAD  = 3'd2,
        PH_PARK  = 3'd3,
        PH_LOW   = 3'd4,
        PH_HIGH  = 3'd5,
        PH_SLOW  = 3'd6,
        PH_SHIGH = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        OP_BIT   = 2'd0,
        OP_START = 2'd1,
        OP_STOP  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

endpackage

// File: rtl/scl_cnt_decode.sv
module scl_cnt_decode #(
    parameter int CNT_W    = 16,
    parameter int LO_EXTRA = 2,
    parameter int HI_EXTRA = 7,
    localparam int PW      = CNT_W + 1
) (
    input  logic [2*CNT_W-1:0] tim_high_i,
    input  logic [2*CNT_W-1:0] tim_low_i,
    input  logic [2*CNT_W-1:0] tim_edge_i,
    output logic [PW-1:0]      len_high_o,
    output logic [PW-1:0]      len_low_o,
    output logic [PW-1:0]      pos_rx_o,
    output logic [PW-1:0]      pos_tx_o,
    output logic [PW-1:0]      len_lead_o,
    output logic [PW-1:0]      len_bf_o
);
    localparam int NFIELD = 6;

    logic [2*CNT_W-1:0] word [3];
    logic [CNT_W-1:0]   raw  [NFIELD];
    logic [PW-1:0]      effv [NFIELD];

    assign word[0] = tim_high_i;
    assign word[1] = tim_low_i;
    assign word[2] = tim_edge_i;

    // field order: 0 high, 1 rx, 2 low, 3 tx, 4 bus-free, 5 lead-in
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        if (g % 2 == 0) begin : g_upper
            assign raw[g] = word[g/2][2*CNT_W-1:CNT_W];
        end else begin : g_lower
            assign raw[g] = word[g/2][CNT_W-1:0];
        end
        assign effv[g] = (raw[g] == '0) ? PW'(1) : {1'b0, raw[g]};
    end

    always_comb begin
        len_high_o = effv[0] + PW'(HI_EXTRA);
        len_low_o  = effv[2] + PW'(LO_EXTRA);
        pos_rx_o   = (effv[1] > len_high_o - PW'(1)) ? len_high_o - PW'(1) : effv[1];
        pos_tx_o   = (effv[3] > len_low_o - PW'(2))  ? len_low_o - PW'(2)  : effv[3];
        len_bf_o   = effv[4];
        len_lead_o = effv[5];
    end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import i2c_scl_timer_pkg::*;
#(
    parameter int PW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_go_i,
    input  logic [1:0]    op_i,
    input  logic          hold_i,
    input  logic [PW-1:0] len_high_i,
    input  logic [PW-1:0] len_low_i,
    input  logic [PW-1:0] pos_rx_i,
    input  logic [PW-1:0] pos_tx_i,
    input  logic [PW-1:0] len_lead_i,
    input  logic [PW-1:0] len_bf_i,
    output logic          scl_o,
    output logic          tx_stb_o,
    output logic          rx_stb_o,
    output logic          start_phase_o,
    output logic          stop_phase_o,
    output logic          bus_idle_o,
    output logic          bit_ready_o
);
    typedef struct packed {
        phase_e        ph;
        logic [PW-1:0] cnt;
    } seq_s;

    seq_s   s_d, s_q;
    phase_e disp;
    logic   last_lead, last_low, last_high, last_bf;

    always_comb begin
        last_lead = (s_q.cnt == len_lead_i - PW'(1));
        last_low  = (s_q.cnt == len_low_i - PW'(1));
        last_high = (s_q.cnt == len_high_i - PW'(1));
        last_bf   = (s_q.cnt == len_bf_i - PW'(1));

        if (op_go_i && op_i == OP_BIT)       disp = PH_LOW;
        else if (op_go_i && op_i == OP_STOP) disp = PH_SLOW;
        else                                 disp = PH_PARK;

        s_d     = s_q;
        s_d.cnt = s_q.cnt + PW'(1);
        unique case (s_q.ph)
            PH_IDLE: begin
                s_d.cnt = '0;
                if (op_go_i && op_i == OP_START) s_d.ph = PH_LEAD;
            end
            PH_BFREE: begin
                if (last_bf) begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end
            end
            PH_LEAD: begin
                if (last_lead) begin
                    s_d.ph  = disp;
                    s_d.cnt = '0;
                end
            end
            PH_PARK: begin
                s_d.ph  = disp;
                s_d.cnt = '0;
            end
            PH_LOW, PH_SLOW: begin
                if (last_low) begin
                    if (hold_i) begin
                        s_d.cnt = s_q.cnt;
                    end else begin
                        s_d.ph  = (s_q.ph == PH_LOW) ? PH_HIGH : PH_SHIGH;
                        s_d.cnt = '0;
                    end
                end
            end
            PH_HIGH: begin
                if (last_high) begin
                    s_d.ph  = disp;
                    s_d.cnt = '0;
                end
            end
            PH_SHIGH: begin
                if (last_high) begin
                    s_d.ph  = PH_BFREE;
                    s_d.cnt = '0;
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        scl_o         = !(s_q.ph == PH_PARK || s_q.ph == PH_LOW || s_q.ph == PH_SLOW);
        tx_stb_o      = (s_q.ph == PH_LOW || s_q.ph == PH_SLOW) && (s_q.cnt == pos_tx_i);
        rx_stb_o      = (s_q.ph == PH_HIGH) && (s_q.cnt == pos_rx_i);
        start_phase_o = (s_q.ph == PH_LEAD);
        stop_phase_o  = (s_q.ph == PH_SLOW || s_q.ph == PH_SHIGH);
        bus_idle_o    = (s_q.ph == PH_IDLE);
        bit_ready_o   = (s_q.ph == PH_PARK) || (s_q.ph == PH_LEAD && last_lead)
                     || (s_q.ph == PH_HIGH && last_high);
    end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int CNT_W    = 16,
    parameter int LO_EXTRA = 2,
    parameter int HI_EXTRA = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_go_i,
    input  logic [1:0]         op_i,
    input  logic               hold_i,
    input  logic [2*CNT_W-1:0] tim_high_i,
    input  logic [2*CNT_W-1:0] tim_low_i,
    input  logic [2*CNT_W-1:0] tim_edge_i,
    output logic               scl_o,
    output logic               tx_stb_o,
    output logic               rx_stb_o,
    output logic               start_phase_o,
    output logic               stop_phase_o,
    output logic               bus_idle_o,
    output logic               bit_ready_o
);
    localparam int PW = CNT_W + 1;

    logic [PW-1:0] len_high, len_low, pos_rx, pos_tx, len_lead, len_bf;

    scl_cnt_decode #(
        .CNT_W    (CNT_W),
        .LO_EXTRA (LO_EXTRA),
        .HI_EXTRA (HI_EXTRA)
    ) u_decode (
        .tim_high_i (tim_high_i),
        .tim_low_i  (tim_low_i),
        .tim_edge_i (tim_edge_i),
        .len_high_o (len_high),
        .len_low_o  (len_low),
        .pos_rx_o   (pos_rx),
        .pos_tx_o   (pos_tx),
        .len_lead_o (len_lead),
        .len_bf_o   (len_bf)
    );

    scl_phase_seq #(
        .PW (PW)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_go_i       (op_go_i),
        .op_i          (op_i),
        .hold_i        (hold_i),
        .len_high_i    (len_high),
        .len_low_i     (len_low),
        .pos_rx_i      (pos_rx),
        .pos_tx_i      (pos_tx),
        .len_lead_i    (len_lead),
        .len_bf_i      (len_bf),
        .scl_o         (scl_o),
        .tx_stb_o      (tx_stb_o),
        .rx_stb_o      (rx_stb_o),
        .start_phase_o (start_phase_o),
        .stop_phase_o  (stop_phase_o),
        .bus_idle_o    (bus_idle_o),
        .bit_ready_o   (bit_ready_o)
    );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic tx_stb_o,
    input logic rx_stb_o,
    input logic start_phase_o,
    input logic stop_phase_o,
    input logic bus_idle_o,
    input logic bit_ready_o
);
    // R2
    start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_phase_o |-> scl_o);

    // R2
    lead_ends_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_phase_o) |-> !scl_o);

    // R5
    tx_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_o |-> !scl_o);

    // R5
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_o |=> !tx_stb_o);

    // R6
    rx_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb_o |-> scl_o && !stop_phase_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle_o |-> scl_o && !start_phase_o && !stop_phase_o && !bit_ready_o);

    // R7
    stop_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_phase_o |-> !bit_ready_o && !start_phase_o);

endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_o         (scl_o),
    .tx_stb_o      (tx_stb_o),
    .rx_stb_o      (rx_stb_o),
    .start_phase_o (start_phase_o),
    .stop_phase_o  (stop_phase_o),
    .bus_idle_o    (bus_idle_o),
    .bit_ready_o   (bit_ready_o)
);

// File: tb/i2c_scl_timer_tb.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_go = 1'b0;
    logic [1:0]  op = 2'd3;
    logic        hold = 1'b0;
    logic [31:0] tim_high = '0, tim_low = '0, tim_edge = '0;
    logic scl_o, tx_stb_o, rx_stb_o, start_phase_o, stop_phase_o, bus_idle_o, bit_ready_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_scl_timer u_dut (
        .clk (clk), .rst_n (rst_n), .op_go_i (op_go), .op_i (op), .hold_i (hold),
        .tim_high_i (tim_high), .tim_low_i (tim_low), .tim_edge_i (tim_edge),
        .scl_o (scl_o), .tx_stb_o (tx_stb_o), .rx_stb_o (rx_stb_o),
        .start_phase_o (start_phase_o), .stop_phase_o (stop_phase_o),
        .bus_idle_o (bus_idle_o), .bit_ready_o (bit_ready_o)
    );

    // hi, rx, lo, tx, lead, bf
    localparam int NV = 4;
    localparam int VEC [NV][6] = '{
        '{20, 8, 25, 9, 14, 30},
        '{0, 0, 0, 0, 0, 0},        // R9 all zero
        '{3, 50, 5, 40, 3, 2},      // offsets clipped
        '{60, 22, 70, 26, 100, 112}
    };

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input string req, input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual %0d expected %0d", req, tag, act, exp);
        end
    endtask

    // R11: field placement of the timing words
    task automatic set_tim(input int hi, input int rx, input int lo, input int tx,
                           input int lead, input int bf);
        tim_high = {hi[15:0], rx[15:0]};
        tim_low  = {lo[15:0], tx[15:0]};
        tim_edge = {bf[15:0], lead[15:0]};
    endtask

    // count consecutive samples with scl at lvl and stop phase at sp
    task automatic run_len(input logic lvl, input logic sp, output int len,
                           output int pos, output int nstb);
        len = 0; pos = -1; nstb = 0;
        while (scl_o == lvl && stop_phase_o == sp && len < 70000) begin
            if (lvl ? rx_stb_o : tx_stb_o) begin
                if (pos < 0) pos = len;
                nstb++;
            end
            len++;
            @(negedge clk);
        end
    endtask

    task automatic do_start(input logic keep_bit, output int lead);
        @(negedge clk);
        op_go = 1'b1; op = 2'd1;
        @(negedge clk);
        op = 2'd0;
        op_go = keep_bit;
        lead = 0;
        while (start_phase_o && scl_o && lead < 70000) begin
            lead++;
            @(negedge clk);
        end
    endtask

    task automatic frame(input int hi, input int rx, input int lo, input int tx,
                         input int lead, input int bf, input string tag);
        int L, H, ptx, prx, n, len, pos, ns;
        L = eff(lo) + 2; H = eff(hi) + 7;
        ptx = imin(eff(tx), L - 2); prx = imin(eff(rx), H - 1);
        set_tim(hi, rx, lo, tx, lead, bf);
        do_start(1'b1, n);
        chk("R2 lead-in width", tag, n, eff(lead));
        chk("R2 scl falls after lead", tag, int'(scl_o), 0);
        for (int b = 0; b < 2; b++) begin
            run_len(1'b0, 1'b0, len, pos, ns);
            chk("R3 low width", tag, len, L);
            chk("R5 tx strobe offset", tag, pos, ptx);
            chk("R5 tx strobe count", tag, ns, 1);
            if (b == 1) op = 2'd2;
            run_len(1'b1, 1'b0, len, pos, ns);
            chk("R4 high width", tag, len, H);
            chk("R6 rx strobe offset", tag, pos, prx);
            chk("R6 rx strobe count", tag, ns, 1);
        end
        chk("R7 stop phase entered", tag, int'(stop_phase_o), 1);
        op_go = 1'b0;
        run_len(1'b0, 1'b1, len, pos, ns);
        chk("R7 stop low width", tag, len, L);
        run_len(1'b1, 1'b1, len, pos, ns);
        chk("R7 stop high width", tag, len, H);
        n = 0;
        while (!bus_idle_o && scl_o && n < 70000) begin n++; @(negedge clk); end
        chk("R7 bus free width", tag, n, eff(bf));
    endtask

    initial begin : main
        int n, len, pos, ns, bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", "reset",
            {scl_o, bus_idle_o, start_phase_o, stop_phase_o, bit_ready_o, tx_stb_o, rx_stb_o},
            7'b1100000);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: BIT while idle is ignored
        set_tim(20, 8, 25, 9, 14, 30);
        op_go = 1'b1; op = 2'd0; bad = 0;
        repeat (4) begin
            @(negedge clk);
            if (!scl_o || !bus_idle_o || tx_stb_o) bad++;
        end
        op_go = 1'b0;
        chk("R10 BIT ignored while idle", "idle", bad, 0);

        for (int v = 0; v < NV; v++)
            frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                  (v == 1) ? "R9 zero counts" : "R11 table");

        // R8 hold stretches low phase
        set_tim(20, 8, 25, 9, 14, 30);
        do_start(1'b1, n);
        hold = 1'b1;
        len = 0; ns = 0;
        for (int i = 0; i < 40; i++) begin
            if (!scl_o) len++;
            if (tx_stb_o) ns++;
            @(negedge clk);
        end
        hold = 1'b0;
        run_len(1'b0, 1'b0, n, pos, bad);
        chk("R8 held low width", "hold", len + n, 41);
        chk("R8 tx strobe once while held", "hold", ns + bad, 1);
        op = 2'd2;
        run_len(1'b1, 1'b0, len, pos, ns);
        chk("R8 high after hold", "hold", len, 27);
        op_go = 1'b0;
        while (!bus_idle_o) @(negedge clk);

        // R12 park, R10 START ignored while parked and in bus-free
        do_start(1'b0, n);
        chk("R12 parked low ready", "park", {scl_o, bit_ready_o}, 2'b01);
        op_go = 1'b1; op = 2'd1; bad = 0;
        repeat (3) begin
            @(negedge clk);
            if (scl_o || start_phase_o || !bit_ready_o) bad++;
        end
        chk("R10 START ignored while parked", "park", bad, 0);
        op = 2'd2;
        @(negedge clk);
        op_go = 1'b0;
        chk("R12 STOP taken from park", "park", int'(stop_phase_o), 1);
        while (stop_phase_o) @(negedge clk);
        op_go = 1'b1; op = 2'd1;
        n = 0; bad = 0;
        while (!bus_idle_o && n < 1000) begin
            if (start_phase_o || !scl_o) bad++;
            n++;
            if (n == 3) op_go = 1'b0;
            @(negedge clk);
        end
        chk("R10 START ignored in bus free", "bfree", bad, 0);
        chk("R7 bus free unchanged", "bfree", n, 30);

        // wide high count needs the extra counter bit
        set_tim(16'hFFFC, 5, 4, 2, 2, 2);
        do_start(1'b1, n);
        op_go = 1'b0;
        run_len(1'b0, 1'b0, len, pos, ns);
        run_len(1'b1, 1'b0, len, pos, ns);
        chk("R4 wide high width", "wide", len, 32'hFFFC + 7);
        chk("R12 parks after high", "wide", {scl_o, bit_ready_o}, 2'b01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule